// File: doc/BRIEF.md
# Multi-Converter Acquisition Sequencer

This block runs a bank of eight external successive-approximation converters as one acquisition unit. A bus write that lands anywhere in the bank's address region starts a cycle. The block pulls every chip select and the shared write-start strobe low together, so all converters begin sampling at the same moment. Their active-low end-of-conversion lines are combined, and the merged condition passes through a synchronizer. The block starts reading only when the slowest converter has finished.

Once the bank is complete, the converters are unloaded one at a time in ascending index order. Each one gets a two-cycle read strobe with only its own chip select active. The result is captured on the clock edge that ends the strobe. It is stored at a base address plus the converter index in a small on-block result memory, and the address wraps modulo the memory depth. A one-cycle done pulse closes a successful acquisition. If the bank does not report completion within a programmable number of cycles, the acquisition is abandoned and an error flag is raised. That flag stays set until the next accepted start or a reset.

Top module: `adc_bank_sequencer`

## Requirements
- R1: A start is accepted only from idle, on a cycle with `busWrEn` high and `busAddr[ADDR_W-1:ADDR_W-4]` equal to `REGION` (default 4'h5). The lower address bits are ignored, and writes to any other region start nothing.
- R2: An accepted start drives `adcWrN` low together with all eight `adcCsN` bits for exactly two consecutive cycles.
- R3: `adcRdN` never goes low while any `adcIntrN` bit is high. Reading begins only after all eight lines are low and the low level has passed the two-stage synchronizer.
- R4: Converters are read in the order 0, 1, … 7. While `adcRdN` is low exactly one `adcCsN` bit is low, and each converter holds it for exactly two cycles. `adcRdN` returns high after converter 7.
- R5: The result of converter i is bits `[8i+7:8i]` of `adcData`, captured at the end of its read strobe. It is stored at location `(bufBase + i) mod MEM_DEPTH`, where `bufBase` is latched at start, and can be read combinationally at `rdAddr`/`rdData`.
- R6: `busy` is high from the cycle after an accepted start until the acquisition ends. `done` pulses high for exactly one cycle, with `busy` still high, after the eighth result is written.
- R7: A start request that arrives while `busy` is high has no effect: no extra write-start strobe and no extra done pulse.
- R8: If completion is not seen within `cfgTimeout` cycles of waiting, the block returns to idle with `errFlag` high and no read strobe or done pulse. The next accepted start clears `errFlag`.
- R9: A synchronous active-high `rst` returns the block to idle from any state, with `busy`, `done` and `errFlag` low and all strobes (`adcWrN`, `adcRdN`, `adcCsN`) high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Bus write qualifier for the start command |
| busAddr | input | ADDR_W | Bus address; upper nibble decoded against REGION |
| bufBase | input | MEM_AW | Result memory base address, latched at start |
| cfgTimeout | input | TO_W | Maximum wait cycles for bank completion |
| adcIntrN | input | 8 | Per-converter end-of-conversion, active low |
| adcData | input | 8*DATA_W | Per-converter result buses, converter i at slice i |
| rdAddr | input | MEM_AW | Result memory read address |
| rdData | output | DATA_W | Result memory read data (combinational) |
| adcCsN | output | 8 | Per-converter chip selects, active low |
| adcWrN | output | 1 | Shared write-start strobe, active low |
| adcRdN | output | 1 | Shared read strobe, active low |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | One-cycle acquisition complete pulse |
| errFlag | output | 1 | Last acquisition timed out |

## Verification
The bench uses the default parameters: eight converters, 8-bit data, a 16-entry result memory, a 16-bit bus address with region 5 and a two-stage synchronizer. With a 16-entry memory, a base of 12 wraps partway through the bank, so the modulo addressing of R5 is exercised. `cfgTimeout` is set to 30 cycles. Converter delays of 3 to 20 cycles therefore complete normally, and a 400-cycle converter forces the abort path. Staggered per-converter delays make the last converter to finish a different one in different runs, so the completion merge is checked against a slow converter that is not always the same one.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int unsigned NUM_ADC = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_ADC);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } seq_state_e;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic             startAll;  // all chip selects + write-start low
    logic             clrWait;   // clear the wait timer
    logic             cntWait;   // advance the wait timer
    logic             readEn;    // read strobe active
    logic             capture;   // store selected converter result this edge
    logic [IDX_W-1:0] readIdx;   // converter under read
  } seq_strobe_t;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [3:0]  REGION = 4'h5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic        allDoneSync,
  input  logic        armed,
  input  logic        timedOut,
  output seq_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        errFlag
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ADC - 1);

  seq_state_e       state;
  logic             phase;
  logic [IDX_W-1:0] idx;
  logic             startHit;
  logic             bankReady;

  // Coarse region decode: only the upper nibble matters
  assign startHit  = busWrEn && (busAddr[ADDR_W-1 -: 4] == REGION);
  assign bankReady = armed && allDoneSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      idx     <= '0;
      errFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startHit) begin
            state   <= ST_START;
            phase   <= 1'b0;
            errFlag <= 1'b0;
          end
        end
        ST_START: begin
          if (phase) begin
            state <= ST_WAIT;
            phase <= 1'b0;
          end else begin
            phase <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (bankReady) begin
            state <= ST_READ;
            idx   <= '0;
            phase <= 1'b0;
          end else if (timedOut) begin
            state   <= ST_IDLE;
            errFlag <= 1'b1;
          end
        end
        ST_READ: begin
          if (phase) begin
            phase <= 1'b0;
            if (idx == LAST_IDX) begin
              state <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            phase <= 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.startAll = (state == ST_START);
    strobe.clrWait  = (state == ST_START);
    strobe.cntWait  = (state == ST_WAIT);
    strobe.readEn   = (state == ST_READ);
    strobe.capture  = (state == ST_READ) && phase;
    strobe.readIdx  = idx;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe.startAll && startHit) |=> !strobe.startAll); // R7

  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (rst)
    (strobe.cntWait && timedOut && !bankReady) |=> (errFlag && !busy)); // R8

endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MEM_DEPTH   = 16,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  seq_strobe_t               strobe,
  input  logic [NUM_ADC-1:0]        adcIntrN,
  input  logic [NUM_ADC*DATA_W-1:0] adcData,
  input  logic [TO_W-1:0]           cfgTimeout,
  input  logic [MEM_AW-1:0]         bufBase,
  input  logic [MEM_AW-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_ADC-1:0]        adcCsN,
  output logic                      adcWrN,
  output logic                      adcRdN,
  output logic                      allDoneSync,
  output logic                      armed,
  output logic                      timedOut
);

  // ---------------- converter pin decode ----------------
  assign adcWrN = ~strobe.startAll;
  assign adcRdN = ~strobe.readEn;

  for (genvar i = 0; i < NUM_ADC; i++) begin : gCs
    assign adcCsN[i] = ~(strobe.startAll ||
                         (strobe.readEn && (strobe.readIdx == IDX_W'(i))));
  end

  // ---------------- completion merge + synchronizer ----------------
  logic                   mergedDone;
  logic [SYNC_STAGES-1:0] syncChain;

  assign mergedDone = ~(|adcIntrN);

  always_ff @(posedge clk) begin
    if (rst) syncChain <= '0;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], mergedDone};
  end

  assign allDoneSync = syncChain[SYNC_STAGES-1];

  // ---------------- wait timer ----------------
  logic [TO_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (rst || strobe.clrWait) begin
      waitCnt <= '0;
    end else if (strobe.cntWait && (waitCnt != '1)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign timedOut = (waitCnt >= cfgTimeout);
  assign armed    = (waitCnt >= TO_W'(SYNC_STAGES));

  // ---------------- result storage ----------------
  logic [MEM_AW-1:0] baseReg;
  logic [MEM_AW-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] resultMem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (rst)                  baseReg <= '0;
    else if (strobe.startAll) baseReg <= bufBase;
  end

  assign wrAddr = baseReg + MEM_AW'(strobe.readIdx);
  assign wrData = adcData[strobe.readIdx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (strobe.capture) resultMem[wrAddr] <= wrData;
  end

  assign rdData = resultMem[rdAddr];

  AST_WR_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $fell(adcWrN) |=> !adcWrN); // R2

  AST_READ_AFTER_BANK_DONE: assert property (@(posedge clk) disable iff (rst)
    !adcRdN |-> allDoneSync); // R3

  AST_READ_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !adcRdN |-> ($countones(~adcCsN) == 1)); // R4

endmodule

// File: rtl/adc_bank_sequencer.sv
module adc_bank_sequencer
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MEM_DEPTH   = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [3:0]  REGION      = 4'h5,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MEM_AW     = $clog2(MEM_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [MEM_AW-1:0]         bufBase,
  input  logic [TO_W-1:0]           cfgTimeout,
  input  logic [NUM_ADC-1:0]        adcIntrN,
  input  logic [NUM_ADC*DATA_W-1:0] adcData,
  input  logic [MEM_AW-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_ADC-1:0]        adcCsN,
  output logic                      adcWrN,
  output logic                      adcRdN,
  output logic                      busy,
  output logic                      done,
  output logic                      errFlag
);

  seq_strobe_t strobe;
  logic        allDoneSync;
  logic        armed;
  logic        timedOut;

  adcseq_ctrl #(
    .ADDR_W (ADDR_W),
    .REGION (REGION)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .busWrEn     (busWrEn),
    .busAddr     (busAddr),
    .allDoneSync (allDoneSync),
    .armed       (armed),
    .timedOut    (timedOut),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .errFlag     (errFlag)
  );

  adcseq_datapath #(
    .DATA_W      (DATA_W),
    .MEM_DEPTH   (MEM_DEPTH),
    .TO_W        (TO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .adcIntrN    (adcIntrN),
    .adcData     (adcData),
    .cfgTimeout  (cfgTimeout),
    .bufBase     (bufBase),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .adcCsN      (adcCsN),
    .adcWrN      (adcWrN),
    .adcRdN      (adcRdN),
    .allDoneSync (allDoneSync),
    .armed       (armed),
    .timedOut    (timedOut)
  );

endmodule

// File: tb/adc_bank_sequencer_test.sv
`timescale 1ns/1ps
module adc_bank_sequencer_test;

  localparam int NUM = 8;
  localparam int DW  = 8;
  localparam int DEPTH = 16;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          busWrEn = 1'b0;
  logic [15:0]   busAddr = '0;
  logic [AW-1:0] bufBase = '0;
  logic [15:0]   cfgTimeout = 16'd30;
  logic [NUM-1:0] adcIntrN = '0;
  logic [NUM*DW-1:0] adcData;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [NUM-1:0] adcCsN;
  logic          adcWrN, adcRdN, busy, done, errFlag;

  adc_bank_sequencer uut (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .bufBase(bufBase), .cfgTimeout(cfgTimeout), .adcIntrN(adcIntrN),
    .adcData(adcData), .rdAddr(rdAddr), .rdData(rdData), .adcCsN(adcCsN),
    .adcWrN(adcWrN), .adcRdN(adcRdN), .busy(busy), .done(done), .errFlag(errFlag)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------- converter models ----------------
  logic [DW-1:0] convData [NUM];
  int            convDelay [NUM];
  int            convCnt [NUM];

  always_comb
    for (int i = 0; i < NUM; i++) adcData[i*DW +: DW] = convData[i];

  initial begin
    for (int i = 0; i < NUM; i++) begin
      convData[i] = '0; convDelay[i] = 3; convCnt[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NUM; i++) begin
        if (!adcWrN) begin
          adcIntrN[i] = 1'b1;
          convCnt[i]  = convDelay[i];
        end else if (convCnt[i] > 0) begin
          if (convCnt[i] == 1) adcIntrN[i] = 1'b0;
          convCnt[i] = convCnt[i] - 1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic [AW-1:0] addr; logic [DW-1:0] data; } exp_t;
  exp_t expQ[$];

  int wrRun = 0, wrRuns = 0;
  int rdRun = 0, curIdx = 0, readsSeen = 0;
  int doneCount = 0;
  bit doneLast = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // R2: write-start strobe shape
      if (!adcWrN) begin
        wrRun++;
        if (adcCsN != '0) check(0, "R2 cs during start", int'(adcCsN), 0);
      end else if (wrRun != 0) begin
        check(wrRun == 2, "R2 start strobe length", wrRun, 2);
        wrRuns++;
        wrRun = 0;
      end
      // R3 / R4: read sequencing
      if (!adcRdN) begin
        int idx;
        idx = -1;
        if (adcIntrN != '0) check(0, "R3 read before bank complete", int'(adcIntrN), 0);
        if ($countones(~adcCsN) != 1) check(0, "R4 single select", $countones(~adcCsN), 1);
        for (int i = 0; i < NUM; i++) if (!adcCsN[i]) idx = i;
        if (rdRun > 0 && idx == curIdx) begin
          rdRun++;
        end else begin
          if (rdRun > 0) begin
            check(rdRun == 2, "R4 read strobe length", rdRun, 2);
            check(idx == curIdx + 1, "R4 ascending order", idx, curIdx + 1);
          end else begin
            check(idx == 0, "R4 first converter", idx, 0);
          end
          curIdx = idx;
          rdRun = 1;
          readsSeen++;
        end
      end else if (rdRun > 0) begin
        check(rdRun == 2, "R4 last read length", rdRun, 2);
        check(curIdx == NUM - 1, "R4 last converter", curIdx, NUM - 1);
        rdRun = 0;
      end
      // R6: done pulse
      if (done) begin
        doneCount++;
        check(busy == 1'b1, "R6 busy at done", int'(busy), 1);
        check(!doneLast, "R6 done one cycle", 1, 0);
        check(readsSeen == NUM, "R6 done after eighth result", readsSeen, NUM);
        // R5: compare stored results
        while (expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          rdAddr = e.addr;
          #0.4;
          check(rdData == e.data, "R5 stored result", int'(rdData), int'(e.data));
        end
      end
      doneLast = done;
    end else begin
      wrRun = 0; rdRun = 0; doneLast = 0;
    end
  end

  // ---------------- driver ----------------
  task automatic pulseStart(input logic [15:0] addr);
    @(negedge clk);
    busWrEn = 1'b1;
    busAddr = addr;
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = 16'h0000;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic acquire(input logic [15:0] addr, input int base, input int seedv,
                         input int slowIdx, input int slowDelay,
                         input bit expectOk, input bit extraStart);
    int wrBefore, doneBefore;
    bufBase = AW'(base);
    for (int i = 0; i < NUM; i++) begin
      convData[i]  = DW'((seedv * 37 + i * 53 + 11) & 255);
      convDelay[i] = (i == slowIdx) ? slowDelay : 3 + ((i * 5 + seedv) % 7);
      if (expectOk) expQ.push_back('{addr: AW'(base + i), data: convData[i]});
    end
    readsSeen  = 0;
    wrBefore   = wrRuns;
    doneBefore = doneCount;
    pulseStart(addr);
    check(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    if (extraStart) begin
      repeat (4) @(negedge clk);
      pulseStart(16'h5000);   // R7: must be ignored
      repeat (12) @(negedge clk);
      pulseStart(16'h5123);   // R7: ignored during read or wait
    end
    waitIdle();
    @(negedge clk);
    check(wrRuns - wrBefore == 1, "R7 one start strobe per acquisition", wrRuns - wrBefore, 1);
    if (expectOk) begin
      check(doneCount - doneBefore == 1, "R6 one done", doneCount - doneBefore, 1);
      check(errFlag == 1'b0, "R8 error clear", int'(errFlag), 0);
      check(expQ.size() == 0, "R5 all results compared", expQ.size(), 0);
    end else begin
      check(errFlag == 1'b1, "R8 timeout error", int'(errFlag), 1);
      check(doneCount - doneBefore == 0, "R8 no done", doneCount - doneBefore, 0);
      check(readsSeen == 0, "R8 no reads", readsSeen, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(busy == 0, "R9 busy", int'(busy), 0);
    check(done == 0, "R9 done", int'(done), 0);
    check(errFlag == 0, "R9 errFlag", int'(errFlag), 0);
    check(adcWrN == 1 && adcRdN == 1, "R9 strobes", int'({adcWrN, adcRdN}), 3);
    check(adcCsN == '1, "R9 chip selects", int'(adcCsN), 255);

    // R1: writes outside the region and reads in the region start nothing
    pulseStart(16'h4FFF);
    busAddr = 16'h5000;            // region address without write enable
    repeat (6) @(negedge clk);
    busAddr = 16'h0000;
    check(busy == 0, "R1 no start outside region", int'(busy), 0);
    check(wrRuns == 0, "R1 no start strobe", wrRuns, 0);

    // R1/R5: nominal acquisition at base 0
    acquire(16'h5000, 0, 1, 0, 4, 1'b1, 1'b0);
    // R1/R3/R5: coarse decode, wrapping base, slowest converter 7
    acquire(16'h5F37, 12, 2, 7, 20, 1'b1, 1'b0);
    // R7: extra start requests while busy, slow converter 2
    acquire(16'h5AAA, 5, 3, 2, 18, 1'b1, 1'b1);
    // R8: converter 3 never finishes in time
    acquire(16'h5000, 0, 4, 3, 400, 1'b0, 1'b0);

    // R9: reset clears the error flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(errFlag == 0, "R9 reset clears error", int'(errFlag), 0);

    // R8: error flag cleared by next start after a timeout
    acquire(16'h5000, 0, 5, 3, 400, 1'b0, 1'b0);
    acquire(16'h5001, 8, 6, 6, 15, 1'b1, 1'b0);

    // R9: reset in the middle of an acquisition
    pulseStart(16'h5000);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R9 mid-run reset busy", int'(busy), 0);
    check(adcWrN == 1 && adcRdN == 1 && adcCsN == '1, "R9 mid-run reset strobes",
          int'({adcWrN, adcRdN}), 3);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule